// File: doc/BRIEF.md
# Numerically Controlled Square-Wave Generator

This block turns a 16-bit control word into a square wave whose frequency scales linearly with the word. On every cycle in which the reference tick input is high, a 16-bit phase accumulator advances by an effective step derived from the control word. Its most significant bit is the square-wave output. The output frequency is the effective step times the tick rate divided by 65536. With a nominal 27 MHz tick, one step unit is about 412 Hz.

The control word is folded before use. Words below 0x8000 are used unchanged. Words at or above 0x8000 are replaced by their 16-bit two's complement, so 0xFFFF gives the same step as 0x0001. Software loads the word one byte at a time, through two byte-enable strobes that share one data byte.

A one-cycle rising-edge strobe comes with the wave. A downstream fixed-frequency stage uses that strobe as its count enable, and an output selector uses the wave itself.

Top module: `nco_freq_gen`

## Requirements
- R1: After reset the accumulator and the control word are zero, `wave_o` and `rise_o` are 0, and the output stays low while ticks arrive until a new word is written.
- R2: When `wr_en_i[1]` is high, bits 15:8 of the control word take `wdata_i` at the clock edge and bits 7:0 keep their value. When `wr_en_i[0]` is high, bits 7:0 take `wdata_i` and bits 15:8 keep their value. The new word is used from the first tick edge after the write edge.
- R3: For a control word c with c < 0x8000, the effective step is c. For c >= 0x8000, the effective step is (65536 - c) mod 65536, so 0x8000 folds to itself.
- R4: At each clock edge where `tick_i` is 1, the accumulator becomes (accumulator + step) mod 65536. At an edge where `tick_i` is 0, the accumulator keeps its value.
- R5: `wave_o` equals accumulator bit 15 at all times.
- R6: `rise_o` is 1 for exactly the one cycle in which `wave_o` reads 1 and read 0 in the previous cycle. It is 0 in every other cycle.
- R7: An effective step of zero freezes the accumulator. Starting from reset, the output then stays low and no strobe is produced.
- R8: For a control word of 2^k (1 <= k <= 15) loaded from reset with `tick_i` held high, the output has a period of 65536/2^k ticks, is high for exactly half of them, and produces one strobe per period.
- R9: For any non-zero step s, and with `tick_i` held high for 65536 ticks starting from a zero accumulator, `rise_o` pulses exactly s times and `wave_o` is high for exactly 32768 of those cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Reference tick; the accumulator advances on edges where this is high |
| wr_en_i | input | 2 | Byte write enables: bit 1 writes control-word bits 15:8, bit 0 writes bits 7:0 |
| wdata_i | input | 8 | Byte written into the enabled lane(s) |
| wave_o | output | 1 | Square-wave output (accumulator bit 15) |
| rise_o | output | 1 | One-cycle strobe on each 0-to-1 transition of `wave_o` |

## Verification
The assertions assume that `tick_i` and `wr_en_i` are clean, synchronous levels that are defined whenever reset is released. They allow a tick and a write in the same cycle. In that case the edge must use the old step, and the assertions check this.

The stimulus drives every input half a period away from the active edge. It mostly writes the control word while ticks are paused. One deliberate case writes during a tick to exercise the old-step rule. A pseudo-random tick pattern covers tick gating. The bench model of the accumulator is advanced only on the edges where the bench itself drove the tick high.

// File: rtl/nco_pkg.sv
package nco_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned CW_W_DEF = 16;
endpackage

// File: rtl/nco_cword_reg.sv
module nco_cword_reg
  import nco_pkg::*;
#(
  parameter  int unsigned CW_W = CW_W_DEF,
  localparam int unsigned NB   = CW_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NB-1:0]     wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [CW_W-1:0]   cword_o
);

  // one register per byte lane, each with its own write enable
  for (genvar g = 0; g < NB; g++) begin : g_lane
    logic [BYTE_W-1:0] lane_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          lane_q <= '0;
      else if (wr_en_i[g])  lane_q <= wdata_i;
    end

    assign cword_o[g*BYTE_W +: BYTE_W] = lane_q;
  end

endmodule

// File: rtl/nco_step.sv
module nco_step #(
  parameter int unsigned W = 16
) (
  input  logic [W-1:0] cword_i,
  output logic [W-1:0] step_o
);

  // fold the upper half of the code space back onto the lower half
  always_comb begin
    if (cword_i[W-1]) step_o = -cword_i;
    else              step_o = cword_i;
  end

endmodule

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
  parameter int unsigned W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         tick_i,
  input  logic [W-1:0] step_i,
  output logic [W-1:0] acc_o,
  output logic         wave_o,
  output logic         rise_o
);

  logic [W-1:0] acc_q;
  logic         wave_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (tick_i) acc_q <= acc_q + step_i;
  end

  // previous output sampled every clock, not only on ticks
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wave_prev_q <= 1'b0;
    else         wave_prev_q <= acc_q[W-1];
  end

  assign acc_o  = acc_q;
  assign wave_o = acc_q[W-1];
  assign rise_o = acc_q[W-1] & ~wave_prev_q;

endmodule

// File: rtl/nco_freq_gen.sv
module nco_freq_gen
  import nco_pkg::*;
#(
  parameter  int unsigned CW_W = CW_W_DEF,
  localparam int unsigned NB   = CW_W / BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [NB-1:0]     wr_en_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic              wave_o,
  output logic              rise_o
);

  logic [CW_W-1:0] cword_q;
  logic [CW_W-1:0] step;
  logic [CW_W-1:0] acc_q;

  nco_cword_reg #(.CW_W(CW_W)) u_cword (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .cword_o (cword_q)
  );

  nco_step #(.W(CW_W)) u_step (
    .cword_i (cword_q),
    .step_o  (step)
  );

  nco_phase_acc #(.W(CW_W)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick_i),
    .step_i (step),
    .acc_o  (acc_q),
    .wave_o (wave_o),
    .rise_o (rise_o)
  );

endmodule

// File: rtl/nco_freq_gen_chk.sv
module nco_freq_gen_chk #(
  parameter int unsigned W  = 16,
  parameter int unsigned NB = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic [NB-1:0] wr_en_i,
  input logic [W-1:0]  cword,
  input logic [W-1:0]  step,
  input logic [W-1:0]  acc,
  input logic          wave_o,
  input logic          rise_o
);

  localparam logic [W-1:0] HALF = W'(1) << (W-1);

  // R2
  cword_hi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i[NB-1] |=> $stable(cword[W-1 -: 8]));

  // R2
  cword_lo_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i[0] |=> $stable(cword[7:0]));

  // R3
  step_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step <= HALF);

  // R3
  step_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cword == '0) |-> (step == '0));

  // R4
  acc_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_i |=> $stable(acc));

  // R4
  acc_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (acc == W'($past(acc) + $past(step))));

  // R6
  rise_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |-> (wave_o && !$past(wave_o)));

  // R6
  rise_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);

  // R7
  zero_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step == '0 && !wave_o) |=> !rise_o);

endmodule

bind nco_freq_gen nco_freq_gen_chk #(.W(CW_W), .NB(NB)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .tick_i  (tick_i),
  .wr_en_i (wr_en_i),
  .cword   (cword_q),
  .step    (step),
  .acc     (acc_q),
  .wave_o  (wave_o),
  .rise_o  (rise_o)
);

// File: tb/nco_freq_gen_test.sv
`timescale 1ns/1ps
module nco_freq_gen_test;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tick_i = 1'b0;
  logic [1:0] wr_en_i = 2'b00;
  logic [7:0] wdata_i = 8'h00;
  logic       wave_o, rise_o;

  int checks = 0;
  int failures = 0;

  // bench model
  logic [15:0] m_cw, m_acc;
  int mism, first_act, first_exp;
  int highs, rises;

  always #2.5 clk_i = ~clk_i;

  nco_freq_gen uut (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick_i),
    .wr_en_i (wr_en_i),
    .wdata_i (wdata_i),
    .wave_o  (wave_o),
    .rise_o  (rise_o)
  );

  function automatic logic [15:0] eff_step(input logic [15:0] c);
    logic [16:0] t;
    if (c < 16'h8000) return c;
    t = 17'h10000 - {1'b0, c};
    return t[15:0];
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // one clock; called and returns at a negative edge
  task automatic cyc(input bit tk, input logic [1:0] we, input logic [7:0] d);
    logic pw, ew, er;
    logic [1:0] got, exp;
    tick_i = tk; wr_en_i = we; wdata_i = d;
    pw = m_acc[15];
    @(posedge clk_i);
    if (tk) m_acc = m_acc + eff_step(m_cw);
    if (we[1]) m_cw[15:8] = d;
    if (we[0]) m_cw[7:0]  = d;
    @(negedge clk_i);
    tick_i = 1'b0; wr_en_i = 2'b00;
    ew = m_acc[15];
    er = ew & ~pw;
    if (wave_o) highs++;
    if (rise_o) rises++;
    got = {wave_o, rise_o};
    exp = {ew, er};
    if (got !== exp) begin
      if (mism == 0) begin first_act = int'(got); first_exp = int'(exp); end
      mism++;
    end
  endtask

  task automatic clear_stats();
    mism = 0; highs = 0; rises = 0; first_act = 0; first_exp = 0;
  endtask

  task automatic do_reset();
    @(negedge clk_i);
    rst_ni = 1'b0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1'b1;
    m_acc = '0; m_cw = '0;
  endtask

  task automatic load(input logic [15:0] w);
    cyc(1'b0, 2'b10, w[15:8]);
    cyc(1'b0, 2'b01, w[7:0]);
  endtask

  task automatic run(input int n, input bit tk);
    for (int i = 0; i < n; i++) cyc(tk, 2'b00, 8'h00);
  endtask

  task automatic model_check(input string req, input string what);
    check(mism == 0, req, what, first_act, first_exp);
  endtask

  initial begin
    repeat (190000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 190000, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    int p;
    m_acc = '0; m_cw = '0;
    do_reset();
    @(negedge clk_i);

    // R1 reset state
    check(wave_o == 1'b0, "R1", "wave after reset", wave_o, 0);
    check(rise_o == 1'b0, "R1", "rise after reset", rise_o, 0);

    // R7: zero word, ticks keep coming
    clear_stats();
    run(64, 1'b1);
    check(highs == 0 && rises == 0, "R7", "highs+rises with zero step", highs + rises, 0);
    model_check("R7", "zero step trace");

    // R8: power-of-two words, exactly half high
    for (int k = 1; k <= 15; k++) begin
      do_reset();
      load(16'(1) << k);
      clear_stats();
      p = 65536 >> k;
      run(p, 1'b1);
      check(highs == p / 2, "R8", $sformatf("high count k=%0d", k), highs, p / 2);
      check(rises == 1, "R8", $sformatf("strobes k=%0d", k), rises, 1);
      model_check("R5", $sformatf("trace k=%0d", k));
    end

    // R3: folded words give the mirrored step
    do_reset();
    load(16'hF000);
    clear_stats();
    run(16, 1'b1);
    check(highs == 8 && rises == 1, "R3", "0xF000 behaves as step 0x1000", highs * 10 + rises, 81);
    do_reset();
    load(16'hC000);
    clear_stats();
    run(16, 1'b1);
    check(rises == 4, "R3", "0xC000 strobes in 16 ticks", rises, 4);
    do_reset();
    load(16'h8123);
    clear_stats();
    run(3000, 1'b1);
    model_check("R3", "0x8123 trace");

    // R1: reset mid-run with output high clears everything
    do_reset();
    load(16'h4000);
    run(2, 1'b1);
    do_reset();
    @(negedge clk_i);
    check(wave_o == 1'b0, "R1", "wave after mid-run reset", wave_o, 0);
    clear_stats();
    run(40, 1'b1);
    check(highs == 0, "R1", "word cleared by reset", highs, 0);

    // R2: byte-wise loading, one lane at a time
    do_reset();
    clear_stats();
    cyc(1'b0, 2'b10, 8'h12);
    run(500, 1'b1);
    cyc(1'b0, 2'b01, 8'h34);
    run(500, 1'b1);
    cyc(1'b0, 2'b10, 8'h00);
    run(3000, 1'b1);
    // write during a tick: old step applies at that edge
    cyc(1'b1, 2'b10, 8'h40);
    run(50, 1'b1);
    cyc(1'b1, 2'b11, 8'h07);
    run(500, 1'b1);
    model_check("R2", "byte lane trace");

    // R4 / R6: irregular tick pattern
    do_reset();
    load(16'h0A35);
    clear_stats();
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      cyc(lfsr[0], 2'b00, 8'h00);
    end
    model_check("R4", "gated tick trace");
    check(rises > 0, "R6", "strobes seen under gating", rises, 1);

    // R7: zero step written mid-run freezes the phase
    clear_stats();
    load(16'h0000);
    p = int'(wave_o);
    run(100, 1'b1);
    check(rises == 0, "R7", "no strobes after zero step", rises, 0);
    check(int'(wave_o) == p, "R7", "wave frozen", wave_o, p);
    model_check("R7", "frozen trace");

    // R9: full phase cycle, strobes equal step
    do_reset();
    load(16'h0123);
    clear_stats();
    run(65536, 1'b1);
    check(rises == 16'h0123, "R9", "strobes over 65536 ticks", rises, 16'h0123);
    check(highs == 32768, "R9", "high cycles over 65536 ticks", highs, 32768);
    model_check("R6", "full period trace");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule